// File: doc/BRIEF.md
# Byte-Pointer Channel Register File

This block holds the 16-bit address and word-count registers of a four-channel transfer engine. A processor reaches them over an 8-bit bus with active-low chip select, read and write strobes and a 4-bit register address. A shared low/high byte pointer selects which half of a 16-bit register the bus touches. The pointer flips after every decoded access, so software writes or reads the low byte first and then the high byte. A dedicated clear strobe puts the pointer back to the low byte.

Each register exists twice. The base copy holds the programmed value. The current copy is the working value that the transfer side advances. A bus write loads both copies. A bus read returns the current copy. On the transfer side, each channel has a step input that moves its current address up or down by one, and a decrement input for its current word count. Both copies of every register are exported per channel. An access is counted once per strobe assertion: a strobe held low over several cycles is one access, taken in its first cycle. Read data appears on `dout` one clock after that cycle and holds until the next read. There is no back-pressure: the bus interface accepts every access in the cycle it arrives.

Top module: `dmarf_top`

## Requirements
- R1: An access is decoded only when `cs_n` is 0 and `addr[3]` is 0. Any other strobe changes no register, no pointer and no `dout`.
- R2: `addr[2:1]` selects channel 0 to 3. `addr[0]`=0 selects the address register and `addr[0]`=1 selects the word-count register.
- R3: A write stores `din` into the selected byte of both the base copy and the current copy of the selected register.
- R4: A read puts a byte of the current copy, never the base copy, on `dout` one clock after the strobe's first low cycle. `dout` holds until the next decoded read.
- R5: When the byte pointer is 0, the access uses bits 7:0; when it is 1, the access uses bits 15:8. The pointer toggles once per decoded access, and a strobe held low over several cycles counts as one access.
- R6: Reset and a high `ptr_clr` set the pointer to 0. If `ptr_clr` and an access fall in the same cycle, the access uses the old pointer value and the pointer ends at 0.
- R7: A high-byte read returns bits 15:8 of the register as they stood at the most recent low-byte read, even if the register has moved since.
- R8: `addr_step[c]` changes channel c's current address by +1, or by -1 when `addr_down[c]` is 1, wrapping modulo 2^16. `cnt_dec[c]` decrements channel c's current word count, wrapping from 0 to 0xFFFF.
- R9: A bus write to a register in the same cycle as a transfer-side update of that register wins, and the update is dropped.
- R10: Reset clears all registers to 0. Base copies change only through bus writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs_n | input | 1 | Chip select, active low |
| rd_n | input | 1 | Read strobe, active low |
| wr_n | input | 1 | Write strobe, active low |
| addr | input | 4 | Register address: bit 3 must be 0, bits 2:1 channel, bit 0 kind |
| din | input | 8 | Write data |
| dout | output | 8 | Read data, registered |
| ptr_clr | input | 1 | Byte pointer clear |
| addr_step | input | NCH | Per-channel current address step |
| addr_down | input | NCH | Per-channel step direction, 1 = down |
| cnt_dec | input | NCH | Per-channel current word count decrement |
| cur_addr | output | NCH*16 | Current addresses, channel c at bits 16c+15:16c |
| cur_cnt | output | NCH*16 | Current word counts |
| base_addr | output | NCH*16 | Base addresses |
| base_cnt | output | NCH*16 | Base word counts |

## Verification
Four properties are checked on every cycle. The pointer goes to 0 after a clear. Otherwise it flips exactly when an access is decoded and stays put when none is. The base copies, `dout` and the current addresses stay stable unless a write, a read or a step explains the change. The byte ordering, channel and kind decode, snapshot consistency across a moving register, write-over-step priority, wrap-around and held-strobe handling need concrete values. The bench's scenarios show these through the ports.

// File: rtl/dmarf_pkg.sv
package dmarf_pkg;
  typedef enum logic {
    KIND_ADDR = 1'b0,
    KIND_CNT  = 1'b1
  } reg_kind_e;

  typedef struct packed {
    logic      rd_go;
    logic      wr_go;
    reg_kind_e kind;
    logic      hi;
  } bus_acc_t;
endpackage

// File: rtl/dmarf_decode.sv
module dmarf_decode
  import dmarf_pkg::*;
#(
  parameter int NCH  = 4,
  localparam int CHW = $clog2(NCH)
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           cs_n,
  input  logic           rd_n,
  input  logic           wr_n,
  input  logic [3:0]     addr,
  input  logic           ptr_clr,
  output bus_acc_t       acc,
  output logic [CHW-1:0] ch,
  output logic           ptr
);
  logic sel_ok, rd_act, wr_act, rd_q, wr_q;

  assign sel_ok = !cs_n && !addr[3];
  assign rd_act = sel_ok && !rd_n && wr_n;
  assign wr_act = sel_ok && !wr_n && rd_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_q <= 1'b0;
      wr_q <= 1'b0;
      ptr  <= 1'b0;
    end else begin
      rd_q <= rd_act;
      wr_q <= wr_act;
      if (ptr_clr)                   ptr <= 1'b0;
      else if (acc.rd_go || acc.wr_go) ptr <= !ptr;
    end
  end

  always_comb begin
    acc.rd_go = rd_act && !rd_q;
    acc.wr_go = wr_act && !wr_q;
    acc.kind  = reg_kind_e'(addr[0]);
    acc.hi    = ptr;
  end

  assign ch = addr[CHW:1];
endmodule

// File: rtl/dmarf_chan.sv
module dmarf_chan #(
  parameter int DW = 16,
  parameter int BW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_a,
  input  logic          wr_c,
  input  logic          hi,
  input  logic [BW-1:0] din,
  input  logic          step,
  input  logic          down,
  input  logic          dec,
  output logic [DW-1:0] base_a,
  output logic [DW-1:0] cur_a,
  output logic [DW-1:0] base_c,
  output logic [DW-1:0] cur_c
);
  function automatic logic [DW-1:0] put_byte(logic [DW-1:0] old, logic h, logic [BW-1:0] d);
    logic [DW-1:0] r;
    r = old;
    if (h) r[DW-1:BW] = d;
    else   r[BW-1:0]  = d;
    return r;
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      base_a <= '0;
      cur_a  <= '0;
      base_c <= '0;
      cur_c  <= '0;
    end else begin
      if (wr_a) begin
        base_a <= put_byte(base_a, hi, din);
        cur_a  <= put_byte(cur_a, hi, din);
      end else if (step) begin
        cur_a <= down ? cur_a - 1'b1 : cur_a + 1'b1;
      end
      if (wr_c) begin
        base_c <= put_byte(base_c, hi, din);
        cur_c  <= put_byte(cur_c, hi, din);
      end else if (dec) begin
        cur_c <= cur_c - 1'b1;
      end
    end
  end
endmodule

// File: rtl/dmarf_readmux.sv
module dmarf_readmux
  import dmarf_pkg::*;
#(
  parameter int NCH  = 4,
  parameter int DW   = 16,
  parameter int BW   = 8,
  localparam int CHW = $clog2(NCH)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  bus_acc_t          acc,
  input  logic [CHW-1:0]    ch,
  input  logic [NCH*DW-1:0] cur_a,
  input  logic [NCH*DW-1:0] cur_c,
  output logic [BW-1:0]     dout
);
  logic [DW-1:0] pick;
  logic [BW-1:0] snap;

  assign pick = (acc.kind == KIND_CNT) ? cur_c[ch*DW +: DW] : cur_a[ch*DW +: DW];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dout <= '0;
      snap <= '0;
    end else if (acc.rd_go) begin
      if (acc.hi) begin
        dout <= snap;
      end else begin
        dout <= pick[BW-1:0];
        snap <= pick[DW-1:BW];
      end
    end
  end
endmodule

// File: rtl/dmarf_top.sv
module dmarf_top
  import dmarf_pkg::*;
#(
  parameter int NCH = 4,
  parameter int DW  = 16,
  parameter int BW  = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cs_n,
  input  logic              rd_n,
  input  logic              wr_n,
  input  logic [3:0]        addr,
  input  logic [BW-1:0]     din,
  output logic [BW-1:0]     dout,
  input  logic              ptr_clr,
  input  logic [NCH-1:0]    addr_step,
  input  logic [NCH-1:0]    addr_down,
  input  logic [NCH-1:0]    cnt_dec,
  output logic [NCH*DW-1:0] cur_addr,
  output logic [NCH*DW-1:0] cur_cnt,
  output logic [NCH*DW-1:0] base_addr,
  output logic [NCH*DW-1:0] base_cnt
);
  localparam int CHW = $clog2(NCH);

  bus_acc_t       acc;
  logic [CHW-1:0] ch;
  logic           ptr;
  logic           acc_go;

  assign acc_go = acc.rd_go || acc.wr_go;

  dmarf_decode #(.NCH(NCH)) u_dec (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .rd_n(rd_n), .wr_n(wr_n),
    .addr(addr), .ptr_clr(ptr_clr), .acc(acc), .ch(ch), .ptr(ptr)
  );

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    logic hit;
    assign hit = acc.wr_go && (ch == c[CHW-1:0]);
    dmarf_chan #(.DW(DW), .BW(BW)) u_chan (
      .clk(clk), .rst_n(rst_n),
      .wr_a(hit && acc.kind == KIND_ADDR),
      .wr_c(hit && acc.kind == KIND_CNT),
      .hi(acc.hi), .din(din),
      .step(addr_step[c]), .down(addr_down[c]), .dec(cnt_dec[c]),
      .base_a(base_addr[c*DW +: DW]), .cur_a(cur_addr[c*DW +: DW]),
      .base_c(base_cnt[c*DW +: DW]),  .cur_c(cur_cnt[c*DW +: DW])
    );
  end

  dmarf_readmux #(.NCH(NCH), .DW(DW), .BW(BW)) u_rd (
    .clk(clk), .rst_n(rst_n), .acc(acc), .ch(ch),
    .cur_a(cur_addr), .cur_c(cur_cnt), .dout(dout)
  );
endmodule

// File: rtl/dmarf_chk.sv
module dmarf_chk #(
  parameter int NCH = 4,
  parameter int DW  = 16,
  parameter int BW  = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              ptr_clr,
  input logic              go,
  input logic              ptr,
  input logic              wr_go,
  input logic              rd_go,
  input logic [NCH-1:0]    steps,
  input logic [NCH*DW-1:0] base_a,
  input logic [NCH*DW-1:0] base_c,
  input logic [NCH*DW-1:0] cur_a,
  input logic [BW-1:0]     dout
);
  // R6
  a_r6_clr_zero: assert property (@(posedge clk) disable iff (!rst_n)
    ptr_clr |=> !ptr);
  // R5
  a_r5_toggle: assert property (@(posedge clk) disable iff (!rst_n)
    (go && !ptr_clr) |=> (ptr != $past(ptr)));
  a_r5_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!go && !ptr_clr) |=> $stable(ptr));
  // R10
  a_r10_base_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_go |=> ($stable(base_a) && $stable(base_c)));
  // R4
  a_r4_dout_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_go |=> $stable(dout));
  // R8
  a_r8_cur_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr_go && steps == '0) |=> $stable(cur_a));
endmodule

bind dmarf_top dmarf_chk #(.NCH(NCH), .DW(DW), .BW(BW)) u_chk (
  .clk(clk), .rst_n(rst_n), .ptr_clr(ptr_clr), .go(acc_go), .ptr(ptr),
  .wr_go(acc.wr_go), .rd_go(acc.rd_go), .steps(addr_step),
  .base_a(base_addr), .base_c(base_cnt), .cur_a(cur_addr), .dout(dout)
);

// File: tb/tb_dmarf_top.sv
module tb_dmarf_top;
  localparam int NCH = 4;
  localparam int DW  = 16;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cs_n = 1'b1, rd_n = 1'b1, wr_n = 1'b1, ptr_clr = 1'b0;
  logic [3:0] addr = '0;
  logic [7:0] din = '0;
  logic [7:0] dout;
  logic [NCH-1:0] addr_step = '0, addr_down = '0, cnt_dec = '0;
  logic [NCH*DW-1:0] cur_addr, cur_cnt, base_addr, base_cnt;

  int total = 0, bad = 0;
  logic rd_pend = 1'b0;
  logic [7:0] exp_q[$];
  string tag_q[$];

  always #10 clk = !clk;

  dmarf_top dut (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .rd_n(rd_n), .wr_n(wr_n),
    .addr(addr), .din(din), .dout(dout), .ptr_clr(ptr_clr),
    .addr_step(addr_step), .addr_down(addr_down), .cnt_dec(cnt_dec),
    .cur_addr(cur_addr), .cur_cnt(cur_cnt), .base_addr(base_addr), .base_cnt(base_cnt)
  );

  task automatic check(string tag, logic [15:0] act, logic [15:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // one bus access; strobe low for 'hold' cycles, optional clear and steps alongside
  task automatic bus(logic is_rd, logic cs, logic [3:0] a, logic [7:0] d,
                     int hold, logic clr, logic [NCH-1:0] stp);
    @(negedge clk);
    addr = a; din = d; cs_n = cs; ptr_clr = clr; addr_step = stp;
    if (is_rd) rd_n = 1'b0; else wr_n = 1'b0;
    repeat (hold) @(negedge clk);
    cs_n = 1'b1; rd_n = 1'b1; wr_n = 1'b1; ptr_clr = 1'b0; addr_step = '0;
  endtask

  task automatic wr(logic [3:0] a, logic [7:0] d);
    bus(1'b0, 1'b0, a, d, 1, 1'b0, '0);
  endtask

  task automatic rd(logic [3:0] a, logic [7:0] exp, string tag);
    exp_q.push_back(exp);
    tag_q.push_back(tag);
    @(negedge clk);
    addr = a; cs_n = 1'b0; rd_n = 1'b0; rd_pend = 1'b1;
    @(negedge clk);
    cs_n = 1'b1; rd_n = 1'b1; rd_pend = 1'b0;
  endtask

  task automatic pulse(ref logic [NCH-1:0] v, input logic [NCH-1:0] m, input int n);
    @(negedge clk);
    v = m;
    repeat (n) @(negedge clk);
    v = '0;
  endtask

  // scoreboard monitor
  initial begin
    forever begin
      @(posedge clk);
      if (rd_pend) begin
        #5;
        check(tag_q.pop_front(), {8'h00, dout}, {8'h00, exp_q.pop_front()});
      end
    end
  end

  initial begin
    #(200000 * 20);
    bad++;
    $display("FAIL watchdog actual=running expected=done");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R10 reset dout", {8'h00, dout}, 16'h0000);
    check("R10 reset cur_addr", cur_addr[15:0] | cur_addr[63:48], 16'h0000);
    check("R10 reset base_cnt", base_cnt[47:32], 16'h0000);

    // R2 R3: ch0 address, ch2 count
    wr(4'h0, 8'h34); wr(4'h0, 8'h12);
    @(negedge clk);
    check("R3 ch0 cur_addr", cur_addr[15:0], 16'h1234);
    check("R3 ch0 base_addr", base_addr[15:0], 16'h1234);
    wr(4'h5, 8'hEF); wr(4'h5, 8'hBE);
    @(negedge clk);
    check("R2 ch2 cur_cnt", cur_cnt[47:32], 16'hBEEF);
    check("R2 ch2 base_cnt", base_cnt[47:32], 16'hBEEF);
    check("R2 ch2 addr untouched", cur_addr[47:32], 16'h0000);

    // R4 R5 read low then high
    rd(4'h0, 8'h34, "R5 read low byte");
    rd(4'h0, 8'h12, "R5 read high byte");

    // R1 ignored accesses
    bus(1'b0, 1'b0, 4'h8, 8'hFF, 1, 1'b0, '0);
    bus(1'b0, 1'b1, 4'h0, 8'hFF, 1, 1'b0, '0);
    bus(1'b1, 1'b1, 4'h0, 8'h00, 1, 1'b0, '0);
    @(negedge clk);
    check("R1 no write", cur_addr[15:0], 16'h1234);
    check("R1 dout held", {8'h00, dout}, 16'h0012);
    rd(4'h0, 8'h34, "R1 pointer untouched");
    rd(4'h0, 8'h12, "R1 high after");

    // R5 held strobe counts once
    bus(1'b0, 1'b0, 4'h2, 8'hAA, 3, 1'b0, '0);
    wr(4'h2, 8'h55);
    @(negedge clk);
    check("R5 held strobe", cur_addr[31:16], 16'h55AA);

    // R6 clear strobe
    wr(4'h6, 8'h77);
    @(negedge clk); ptr_clr = 1'b1; @(negedge clk); ptr_clr = 1'b0;
    wr(4'h6, 8'h66); wr(4'h6, 8'h00);
    @(negedge clk);
    check("R6 clear pointer", cur_addr[63:48], 16'h0066);
    bus(1'b0, 1'b0, 4'h6, 8'h11, 1, 1'b1, '0);
    wr(4'h6, 8'h22);
    wr(4'h6, 8'h00);
    @(negedge clk);
    check("R6 clear with access", cur_addr[63:48], 16'h0022);

    // R8 steps and wrap, R10 base unchanged
    pulse(addr_step, 4'b0001, 3);
    @(negedge clk);
    check("R8 step up", cur_addr[15:0], 16'h1237);
    check("R10 base after step", base_addr[15:0], 16'h1234);
    wr(4'h6, 8'h00); wr(4'h6, 8'h00);
    addr_down = 4'b1000;
    pulse(addr_step, 4'b1000, 1);
    addr_down = '0;
    @(negedge clk);
    check("R8 step down wrap", cur_addr[63:48], 16'hFFFF);
    pulse(cnt_dec, 4'b0100, 1);
    @(negedge clk);
    check("R8 count dec", cur_cnt[47:32], 16'hBEEE);
    check("R10 base_cnt kept", base_cnt[47:32], 16'hBEEF);
    wr(4'h3, 8'h00); wr(4'h3, 8'h00);
    pulse(cnt_dec, 4'b0010, 1);
    @(negedge clk);
    check("R8 count wrap", cur_cnt[31:16], 16'hFFFF);

    // R4 count register read returns current copy
    rd(4'h5, 8'hEE, "R4 current low");
    rd(4'h5, 8'hBE, "R4 current high");

    // R7 snapshot
    wr(4'h0, 8'hFF); wr(4'h0, 8'h12);
    rd(4'h0, 8'hFF, "R7 low read");
    pulse(addr_step, 4'b0001, 1);
    @(negedge clk);
    check("R7 register moved", cur_addr[15:0], 16'h1300);
    rd(4'h0, 8'h12, "R7 snapshot high");

    // R9 write beats step
    bus(1'b0, 1'b0, 4'h0, 8'h10, 1, 1'b0, 4'b0001);
    wr(4'h0, 8'h13);
    @(negedge clk);
    check("R9 write wins", cur_addr[15:0], 16'h1310);

    repeat (3) @(negedge clk);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule